// File: doc/BRIEF.md
# Programmed-I/O Strobe Cycle Timer with IORDY Watchdog

This block produces one programmed-I/O read or write strobe cycle on a parallel disk interface for each host request. A cycle runs through three phases of programmable length: an address-valid lead-in before the strobe, the strobe itself, and a recovery gap after it. A 32-bit control word holds the three phase counts and the control bits. The host side uses a request input with a read/write select and receives a one-clock completion pulse.

While the strobe is active, the device may hold IORDY low to ask for more time. When IORDY monitoring is on, the block stretches the strobe for as long as IORDY stays low. A watchdog limits that wait. If IORDY stays low for the full limit, the block sets a sticky timeout flag and finishes the cycle as if the device were ready. It then ignores IORDY until software clears the flag by writing one to it. The flag can drive an interrupt output. Two more control bits drive the device reset pin and turn off the device-side output drivers.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x6515_0100. The control word fields are as follows. Bits [31:28] hold the setup count. Bits [27:22] hold the active count. Bits [21:16] hold the recovery count. Bit 8 enables IORDY monitoring. Bit 6 enables the interrupt. Bit 5 enables the watchdog. Bit 4 is the timeout flag. Bit 1 turns the outputs off (tri-state). Bit 0 drives the channel reset. All other bits read as zero.
- R2: A request is taken only in a clock where the block is idle. From the next clock on, `busy` and `dev_addr_valid` stay high for Ls + La + Lr clocks. Here Ls, La and Lr are the setup, active and recovery counts, and a count of 0 counts as 1. The strobe is low for exactly La of those clocks when it is not stretched.
- R3: With `req_write`=0 the strobe is `dev_rd_n`; with `req_write`=1 it is `dev_wr_n`. The other strobe stays high, and both are high outside the active phase.
- R4: `done` is high for exactly one clock, the clock after the last recovery clock. A `req` held high while the block is busy starts no cycle.
- R5: With monitoring on and the flag clear, each clock edge in the active phase that sees IORDY low keeps the strobe low. If IORDY is low for k clocks from the start of the strobe, the strobe lasts max(La, k+1) clocks. With monitoring off, IORDY has no effect.
- R6: With the watchdog and monitoring both on, the 256th consecutive active-phase clock edge that sees IORDY low sets the timeout flag. The strobe then ends one clock later, giving a 257-clock strobe. With the watchdog off, no timeout occurs, however long IORDY stays low.
- R7: While the flag is set, IORDY is ignored. Writing 1 to bit 4 clears the flag, after which stretching works again. A timeout in the same clock as the clearing write wins.
- R8: `wd_irq` is high exactly while the flag and the interrupt enable bit are both set.
- R9: The channel reset bit drives `dev_rst_n` low. The tri-state bit drives `dev_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Write data for the control word |
| cfg_rdata | output | 32 | Current control word and status |
| req | input | 1 | Start a strobe cycle (taken when idle) |
| req_write | input | 1 | 1 selects a write strobe, 0 a read strobe |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| dev_addr_valid | output | 1 | Device address is being driven |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_iordy | input | 1 | Device ready; low requests a wait |
| dev_oe | output | 1 | Device-side output enable |
| dev_rst_n | output | 1 | Device reset, active low |
| wd_irq | output | 1 | Watchdog timeout interrupt |

## Verification
The assertions assume that software changes the phase counts only while the block is idle. They also assume that IORDY is stable around the clock edge. The stimulus writes the control word only between cycles, never while `busy` is high. It drives IORDY and every other input at the falling edge. IORDY goes low only while a strobe is seen low, and only for a set number of clocks, so each stretch or timeout has a known length.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
   localparam int SETUP_W   = 4;
   localparam int PHASE_W   = 6;
   localparam int WORD_W    = 32;
   localparam int F_SET_LSB = 28;
   localparam int F_ACT_LSB = 22;
   localparam int F_REC_LSB = 16;
   localparam int B_MON     = 8;
   localparam int B_IRQEN   = 6;
   localparam int B_WDEN    = 5;
   localparam int B_TMO     = 4;
   localparam int B_TRI     = 1;
   localparam int B_RST     = 0;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [SETUP_W-1:0] setup;
      logic [PHASE_W-1:0] active;
      logic [PHASE_W-1:0] recov;
      logic               mon;
      logic               irq_en;
      logic               wd_en;
      logic               timeout;
      logic               tristate;
      logic               chan_rst;
   } cfg_t;

   function automatic logic [PHASE_W-1:0] floor_one(input logic [PHASE_W-1:0] c);
      return (c == '0) ? PHASE_W'(1) : c;
   endfunction
endpackage

// File: rtl/pio_tmr_regs.sv
module pio_tmr_regs
   import pio_tmr_pkg::*;
#(
   parameter logic [WORD_W-1:0] RESET_WORD = 32'h6515_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              set_tmo,
   output cfg_t              cfg,
   output logic [WORD_W-1:0] rdata
);
   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.setup    <= RESET_WORD[F_SET_LSB +: SETUP_W];
         cfg_q.active   <= RESET_WORD[F_ACT_LSB +: PHASE_W];
         cfg_q.recov    <= RESET_WORD[F_REC_LSB +: PHASE_W];
         cfg_q.mon      <= RESET_WORD[B_MON];
         cfg_q.irq_en   <= RESET_WORD[B_IRQEN];
         cfg_q.wd_en    <= RESET_WORD[B_WDEN];
         cfg_q.timeout  <= RESET_WORD[B_TMO];
         cfg_q.tristate <= RESET_WORD[B_TRI];
         cfg_q.chan_rst <= RESET_WORD[B_RST];
      end else begin
         if (we) begin
            cfg_q.setup    <= wdata[F_SET_LSB +: SETUP_W];
            cfg_q.active   <= wdata[F_ACT_LSB +: PHASE_W];
            cfg_q.recov    <= wdata[F_REC_LSB +: PHASE_W];
            cfg_q.mon      <= wdata[B_MON];
            cfg_q.irq_en   <= wdata[B_IRQEN];
            cfg_q.wd_en    <= wdata[B_WDEN];
            cfg_q.tristate <= wdata[B_TRI];
            cfg_q.chan_rst <= wdata[B_RST];
         end
         if (set_tmo)
            cfg_q.timeout <= 1'b1;
         else if (we && wdata[B_TMO])
            cfg_q.timeout <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      rdata[F_SET_LSB +: SETUP_W] = cfg_q.setup;
      rdata[F_ACT_LSB +: PHASE_W] = cfg_q.active;
      rdata[F_REC_LSB +: PHASE_W] = cfg_q.recov;
      rdata[B_MON]   = cfg_q.mon;
      rdata[B_IRQEN] = cfg_q.irq_en;
      rdata[B_WDEN]  = cfg_q.wd_en;
      rdata[B_TMO]   = cfg_q.timeout;
      rdata[B_TRI]   = cfg_q.tristate;
      rdata[B_RST]   = cfg_q.chan_rst;
   end

   assign cfg = cfg_q;

   wire unused_wdata = ^{wdata[15:9], wdata[7], wdata[3:2]};
endmodule

// File: rtl/pio_tmr_seq.sv
module pio_tmr_seq
   import pio_tmr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               req_write,
   input  logic [SETUP_W-1:0] setup_cnt,
   input  logic [PHASE_W-1:0] active_cnt,
   input  logic [PHASE_W-1:0] recov_cnt,
   input  logic               ready_ok,
   output phase_e             phase,
   output logic               is_write,
   output logic               done
);
   phase_e             ph_q;
   logic [PHASE_W-1:0] cnt_q;
   logic [PHASE_W-1:0] lim;
   logic               last;
   logic               leave;

   always_comb begin
      unique case (ph_q)
         PH_SETUP:  lim = floor_one(PHASE_W'(setup_cnt));
         PH_ACTIVE: lim = floor_one(active_cnt);
         default:   lim = floor_one(recov_cnt);
      endcase
      last  = (cnt_q >= lim - PHASE_W'(1));
      leave = last && ((ph_q != PH_ACTIVE) || ready_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         cnt_q    <= '0;
         is_write <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (ph_q == PH_IDLE) begin
            if (req) begin
               ph_q     <= PH_SETUP;
               cnt_q    <= '0;
               is_write <= req_write;
            end
         end else if (leave) begin
            cnt_q <= '0;
            unique case (ph_q)
               PH_SETUP:  ph_q <= PH_ACTIVE;
               PH_ACTIVE: ph_q <= PH_RECOV;
               default: begin
                  ph_q <= PH_IDLE;
                  done <= 1'b1;
               end
            endcase
         end else if (!last) begin
            cnt_q <= cnt_q + PHASE_W'(1);
         end
      end
   end

   assign phase = ph_q;
endmodule

// File: rtl/pio_tmr_wdog.sv
module pio_tmr_wdog #(
   parameter int LIMIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_active,
   input  logic mon_live,
   input  logic wd_en,
   input  logic iordy,
   output logic expire
);
   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             counting;

   assign counting = in_active && mon_live && wd_en && !iordy;
   assign expire   = counting && (cnt_q == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (counting && !expire)
         cnt_q <= cnt_q + CNT_W'(1);
      else
         cnt_q <= '0;
   end
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
   import pio_tmr_pkg::*;
#(
   parameter logic [31:0] RESET_WORD = 32'h6515_0100,
   parameter int          WDOG_LIMIT = 256,
   parameter bit          SYNC_IORDY = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        req,
   input  logic        req_write,
   output logic        busy,
   output logic        done,
   output logic        dev_addr_valid,
   output logic        dev_rd_n,
   output logic        dev_wr_n,
   input  logic        dev_iordy,
   output logic        dev_oe,
   output logic        dev_rst_n,
   output logic        wd_irq
);
   if (WDOG_LIMIT < 2) begin : g_bad_limit
      $error("WDOG_LIMIT must be at least 2");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("control word must be 32 bits");
   end

   cfg_t   cfg;
   phase_e phase;
   logic   is_write;
   logic   iordy_s;
   logic   mon_live;
   logic   expire;
   logic   strobe;

   if (SYNC_IORDY) begin : g_iordy_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 2'b11;
         else        sync_q <= {sync_q[0], dev_iordy};
      end
      assign iordy_s = sync_q[1];
   end else begin : g_iordy_direct
      assign iordy_s = dev_iordy;
   end

   assign mon_live = cfg.mon && !cfg.timeout;

   pio_tmr_regs #(.RESET_WORD(RESET_WORD)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .set_tmo (expire),
      .cfg     (cfg),
      .rdata   (cfg_rdata)
   );

   pio_tmr_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .req_write  (req_write),
      .setup_cnt  (cfg.setup),
      .active_cnt (cfg.active),
      .recov_cnt  (cfg.recov),
      .ready_ok   (!(mon_live && !iordy_s)),
      .phase      (phase),
      .is_write   (is_write),
      .done       (done)
   );

   pio_tmr_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_active (phase == PH_ACTIVE),
      .mon_live  (mon_live),
      .wd_en     (cfg.wd_en),
      .iordy     (iordy_s),
      .expire    (expire)
   );

   assign strobe         = (phase == PH_ACTIVE);
   assign busy           = (phase != PH_IDLE);
   assign dev_addr_valid = busy;
   assign dev_rd_n       = !(strobe && !is_write);
   assign dev_wr_n       = !(strobe && is_write);
   assign dev_oe         = !cfg.tristate;
   assign dev_rst_n      = !cfg.chan_rst;
   assign wd_irq         = cfg.timeout && cfg.irq_en;
endmodule

// File: rtl/pio_tmr_chk.sv
module pio_tmr_chk (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic busy,
   input logic done,
   input logic rd_n,
   input logic wr_n,
   input logic addr_valid,
   input logic irq,
   input logic tmo_flag,
   input logic tmo_clear
);
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   a_r2_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> addr_valid);

   a_r2_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));

   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !tmo_clear) |=> tmo_flag);

   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tmo_flag);
endmodule

bind pio_strobe_timer pio_tmr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .busy       (busy),
   .done       (done),
   .rd_n       (dev_rd_n),
   .wr_n       (dev_wr_n),
   .addr_valid (dev_addr_valid),
   .irq        (wd_irq),
   .tmo_flag   (cfg_rdata[pio_tmr_pkg::B_TMO]),
   .tmo_clear  (cfg_we && cfg_wdata[pio_tmr_pkg::B_TMO])
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic        busy, done, dev_addr_valid, dev_rd_n, dev_wr_n;
   logic        dev_iordy = 1'b1;
   logic        dev_oe, dev_rst_n, wd_irq;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   int iordy_budget = 0;

   always #4 clk = ~clk;

   pio_strobe_timer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req(req), .req_write(req_write), .busy(busy),
      .done(done), .dev_addr_valid(dev_addr_valid), .dev_rd_n(dev_rd_n),
      .dev_wr_n(dev_wr_n), .dev_iordy(dev_iordy), .dev_oe(dev_oe),
      .dev_rst_n(dev_rst_n), .wd_irq(wd_irq)
   );

   // behavioural reference: phase number, clocks left in phase, wait counter
   int m_ph, m_left, m_wait, m_s, m_a, m_r;
   bit m_done, m_wr, m_mon, m_ie, m_wde, m_to, m_tri, m_rst;

   function automatic int at_least_one(int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic logic [31:0] m_word();
      return (32'(m_s) << 28) | (32'(m_a) << 22) | (32'(m_r) << 16) |
             (32'(m_mon) << 8) | (32'(m_ie) << 6) | (32'(m_wde) << 5) |
             (32'(m_to) << 4) | (32'(m_tri) << 1) | 32'(m_rst);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_wait = 0; m_done = 0; m_wr = 0;
         m_s = 6; m_a = 20; m_r = 21;
         m_mon = 1; m_ie = 0; m_wde = 0; m_to = 0; m_tri = 0; m_rst = 0;
      end else begin
         bit watching, hit;
         watching = m_mon && !m_to;
         hit = 0;
         if (m_ph == 2 && watching && m_wde && !dev_iordy) begin
            m_wait++;
            if (m_wait == 256) begin hit = 1; m_wait = 0; end
         end else m_wait = 0;
         m_done = 0;
         if (m_ph == 0) begin
            if (req) begin m_ph = 1; m_left = at_least_one(m_s); m_wr = req_write; end
         end else if (m_ph == 1) begin
            if (m_left > 1) m_left--; else begin m_ph = 2; m_left = at_least_one(m_a); end
         end else if (m_ph == 2) begin
            if (m_left > 1) m_left--;
            else if (!(watching && !dev_iordy)) begin m_ph = 3; m_left = at_least_one(m_r); end
         end else begin
            if (m_left > 1) m_left--; else begin m_ph = 0; m_done = 1; end
         end
         if (cfg_we) begin
            m_s = int'(cfg_wdata[31:28]); m_a = int'(cfg_wdata[27:22]);
            m_r = int'(cfg_wdata[21:16]);
            m_mon = cfg_wdata[8]; m_ie = cfg_wdata[6]; m_wde = cfg_wdata[5];
            m_tri = cfg_wdata[1]; m_rst = cfg_wdata[0];
            if (cfg_wdata[4]) m_to = 0;
         end
         if (hit) m_to = 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // every-clock comparison against the reference
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R1 cfg_rdata", cfg_rdata, m_word());
         chk("R2 busy", 32'(busy), 32'(m_ph != 0));
         chk("R2 dev_addr_valid", 32'(dev_addr_valid), 32'(m_ph != 0));
         chk("R3 dev_rd_n", 32'(dev_rd_n), 32'(!(m_ph == 2 && !m_wr)));
         chk("R3 dev_wr_n", 32'(dev_wr_n), 32'(!(m_ph == 2 && m_wr)));
         chk("R4 done", 32'(done), 32'(m_done));
         chk("R8 wd_irq", 32'(wd_irq), 32'(m_to && m_ie));
         chk("R9 dev_oe", 32'(dev_oe), 32'(!m_tri));
         chk("R9 dev_rst_n", 32'(dev_rst_n), 32'(!m_rst));
      end
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R4 watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // device model: IORDY low for a budget of strobe clocks
   always @(negedge clk) begin
      if ((!dev_rd_n || !dev_wr_n) && iordy_budget > 0) begin
         dev_iordy <= 1'b0;
         iordy_budget <= iordy_budget - 1;
      end else begin
         dev_iordy <= 1'b1;
      end
   end

   task automatic wr_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = '0;
   endtask

   task automatic run_cyc(input bit wr, input int budget, input int hold, output int slen);
      slen = 0;
      @(negedge clk);
      iordy_budget = budget;
      req = 1'b1; req_write = wr;
      for (int i = 0; i < hold; i++) @(negedge clk);
      req = 1'b0;
      while (!done) begin
         if (!dev_rd_n || !dev_wr_n) slen++;
         @(negedge clk);
      end
      iordy_budget = 0;
      @(negedge clk);
   endtask

   function automatic logic [31:0] word(int s, int a, int r, bit mon, bit ie,
                                        bit wde, bit clr, bit tri_b, bit rst_b);
      return (32'(s) << 28) | (32'(a) << 22) | (32'(r) << 16) | (32'(mon) << 8) |
             (32'(ie) << 6) | (32'(wde) << 5) | (32'(clr) << 4) |
             (32'(tri_b) << 1) | 32'(rst_b);
   endfunction

   initial begin
      int len;
      repeat (3) @(negedge clk);
      chk("R1 reset word", cfg_rdata, 32'h6515_0100);
      rst_n = 1'b1;
      @(negedge clk);

      run_cyc(1'b0, 0, 1, len);
      chk("R2 default active length (read)", 32'(len), 32'd20);
      run_cyc(1'b1, 0, 1, len);
      chk("R3 default active length (write)", 32'(len), 32'd20);

      wr_cfg(word(0, 0, 0, 1, 1, 1, 0, 0, 0));
      run_cyc(1'b1, 0, 1, len);
      chk("R2 zero counts act as one", 32'(len), 32'd1);

      wr_cfg(word(2, 3, 1, 1, 1, 1, 0, 0, 0));
      run_cyc(1'b0, 5, 3, len);
      chk("R5 stretch by IORDY low 5, R4 req held while busy", 32'(len), 32'd6);
      run_cyc(1'b0, 1, 1, len);
      chk("R5 short IORDY wait inside active count", 32'(len), 32'd3);

      run_cyc(1'b0, 1000, 1, len);
      chk("R6 timeout strobe length", 32'(len), 32'd257);
      chk("R6 timeout flag set", 32'(cfg_rdata[4]), 32'd1);
      chk("R8 irq raised", 32'(wd_irq), 32'd1);
      run_cyc(1'b1, 1000, 1, len);
      chk("R7 IORDY ignored while flag set", 32'(len), 32'd3);

      wr_cfg(word(2, 3, 1, 1, 1, 1, 1, 0, 0));
      chk("R7 flag cleared by write-one", 32'(cfg_rdata[4]), 32'd0);
      chk("R8 irq dropped", 32'(wd_irq), 32'd0);
      run_cyc(1'b0, 4, 1, len);
      chk("R7 stretching resumed", 32'(len), 32'd5);

      wr_cfg(word(1, 3, 2, 0, 1, 1, 0, 0, 0));
      run_cyc(1'b1, 10, 1, len);
      chk("R5 monitoring off ignores IORDY", 32'(len), 32'd3);

      wr_cfg(word(1, 2, 2, 1, 1, 0, 0, 0, 0));
      run_cyc(1'b0, 300, 1, len);
      chk("R6 watchdog off long wait", 32'(len), 32'd301);
      chk("R6 no flag without watchdog", 32'(cfg_rdata[4]), 32'd0);

      wr_cfg(word(1, 2, 2, 1, 0, 1, 0, 0, 0));
      run_cyc(1'b0, 1000, 1, len);
      chk("R6 timeout with irq disabled", 32'(len), 32'd257);
      chk("R8 irq masked", 32'(wd_irq), 32'd0);
      chk("R8 flag still set", 32'(cfg_rdata[4]), 32'd1);

      wr_cfg(word(1, 2, 2, 1, 0, 1, 1, 1, 1));
      chk("R9 tri-state drops dev_oe", 32'(dev_oe), 32'd0);
      chk("R9 channel reset drops dev_rst_n", 32'(dev_rst_n), 32'd0);
      wr_cfg(word(1, 2, 2, 1, 0, 1, 0, 0, 0));
      chk("R9 outputs restored", 32'({dev_oe, dev_rst_n}), 32'd3);

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule